// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits behind a bank of timer channels and converts their expiry events into interrupt signalling. Each channel expiry raises one of 32 interrupt lines, sends a message-write request, or does nothing. Which of these happens depends on that channel's enable, signalling mode (level or edge), message-delivery enable and 5-bit line selector, and on a global enable. Level-mode expiries are recorded in a shared status register that software clears by writing ones.

A legacy replacement mode forces channel 0 onto line 0 and channel 1 onto line 8. While the mode is off, two external legacy interrupt inputs are passed through to those same two lines, and a legacy-timer-enable output is held high. Entering the mode blocks the two inputs and drops that output. Only the request is produced for message delivery: a one-cycle strobe with a 32-bit address and a 32-bit data word. The bus transaction that carries it belongs to the consumer.

Top module: `irq_router`

## Requirements
- R1: With legacy mode off, a channel whose status bit is set or whose edge pulse is active drives the line numbered by its 5-bit selector (`ch_route[5*i+4:5*i]`). Lines selected by several channels are ORed.
- R2: In level mode (`ch_level[i]`=1), an expiry on an enabled channel with message delivery off sets `stat_bits[i]` at the next clock edge. The bit and its line then stay high until something clears them.
- R3: In edge mode (`ch_level[i]`=0), an expiry drives the routed line high for exactly one cycle, starting at the next clock edge, and leaves `stat_bits[i]` at 0.
- R4: When `stat_clr_wr`=1, each set status bit whose `stat_clr_data` bit is 1 clears at the next edge, and its line drops. Bits written as 0 keep their value. An expiry in the same cycle takes precedence over the clear.
- R5: While `ch_enable[i]` or `glb_enable` is 0, the channel's status bit is 0 from the next edge, and its expiries produce no line activity and no message request.
- R6: With `legacy_mode`=1, channel 0 drives line 0 and channel 1 drives line 8, whatever their selectors hold. Other channels keep their selectors.
- R7: With `legacy_mode`=0, line 0 and line 8 follow `legacy_irq_in[0]` and `legacy_irq_in[1]` as sampled at the previous edge, and `legacy_timer_en` is 1. With `legacy_mode`=1, the inputs have no effect on any line and `legacy_timer_en` is 0. On leaving the mode, line 8 at once shows the last sampled `legacy_irq_in[1]`.
- R8: An enabled expiry with `ch_msg_en[i]`=1 pulses `msg_req` for one cycle at the next edge. In that cycle `msg_addr` holds bits 63:32 and `msg_data` holds bits 31:0 of that channel's `ch_msg_word`. No line is driven and the status bit is unchanged. If several channels do this in the same cycle, the lowest index wins.
- R9: A 0-to-1 change of `ch_msg_en[i]` clears `stat_bits[i]` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_expire | input | NUM_CH | Per-channel expiry pulse |
| ch_enable | input | NUM_CH | Per-channel interrupt enable |
| ch_level | input | NUM_CH | 1 = level mode, 0 = edge mode |
| ch_msg_en | input | NUM_CH | Per-channel message-delivery enable |
| ch_route | input | 5*NUM_CH | Per-channel 5-bit line selector |
| ch_msg_word | input | 64*NUM_CH | Per-channel message word (high half address, low half data) |
| glb_enable | input | 1 | Global interrupt enable |
| legacy_mode | input | 1 | Legacy replacement routing |
| stat_clr_wr | input | 1 | Status write strobe |
| stat_clr_data | input | NUM_CH | Write-one-to-clear mask |
| legacy_irq_in | input | 2 | Legacy interrupt inputs for lines 0 and 8 |
| irq_out | output | 32 | Interrupt lines |
| legacy_timer_en | output | 1 | High while legacy mode is off |
| msg_req | output | 1 | One-cycle message-write request |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| stat_bits | output | NUM_CH | Interrupt status register |

## Verification
Directed cases target each of the following in isolation: level versus edge signalling, write-one-to-clear against a simultaneous expiry, the legacy override of channels 0 and 1, restoration of line 8 on leaving legacy mode, and message-enable rising edges. Together they show whether each mode has its own effect. Random stimulus then mixes all of the controls, including shared selectors and simultaneous message expiries. This separates OR-combining of lines and lowest-index message selection from simple per-channel behaviour. A bench model checks every output on every cycle.

// File: rtl/irq_pkg.sv
// Shared constants and the line-selection function for the timer interrupt router.
package irq_pkg;
    localparam int LINES     = 32;
    localparam int ROUTE_W   = 5;
    localparam int MSG_W     = 64;
    localparam int LEG_LINE0 = 0;
    localparam int LEG_LINE1 = 8;

    // Effective line for a channel, honouring the legacy override of channels 0 and 1.
    function automatic logic [ROUTE_W-1:0] eff_line(input logic legacy, input int ch,
                                                   input logic [ROUTE_W-1:0] sel);
        if (legacy && ch == 0) return ROUTE_W'(LEG_LINE0);
        if (legacy && ch == 1) return ROUTE_W'(LEG_LINE1);
        return sel;
    endfunction
endpackage

// File: rtl/irq_status_bank.sv
// Per-channel status bits and edge pulses.
// Assumes fire is already qualified by the channel and global enables.
module irq_status_bank #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] fire,
    input  logic [NUM_CH-1:0] is_level,
    input  logic [NUM_CH-1:0] msg_en,
    input  logic [NUM_CH-1:0] active,
    input  logic [NUM_CH-1:0] clr_mask,
    output logic [NUM_CH-1:0] status,
    output logic [NUM_CH-1:0] pulse
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic st_q, pl_q, msg_q;

        // Status bit update: disable, message-enable rise, expiry, then software clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= 1'b0;
                pl_q  <= 1'b0;
                msg_q <= 1'b0;
            end else begin
                msg_q <= msg_en[ch];
                pl_q  <= fire[ch] & ~is_level[ch] & ~msg_en[ch];
                if (!active[ch])
                    st_q <= 1'b0;
                else if (msg_en[ch] && !msg_q)
                    st_q <= 1'b0;
                else if (fire[ch] && !msg_en[ch])
                    st_q <= is_level[ch];
                else if (clr_mask[ch])
                    st_q <= 1'b0;
            end
        end

        assign status[ch] = st_q;
        assign pulse[ch]  = pl_q;
    end
endmodule

// File: rtl/irq_line_map.sv
// Combines channel activity and legacy inputs into the interrupt lines.
// Assumes status and pulse are registered; this module is purely combinational.
module irq_line_map
    import irq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                      legacy,
    input  logic [NUM_CH*ROUTE_W-1:0] route,
    input  logic [NUM_CH-1:0]         status,
    input  logic [NUM_CH-1:0]         pulse,
    input  logic [NUM_CH-1:0]         msg_en,
    input  logic [1:0]                leg_q,
    output logic [LINES-1:0]          lines
);
    // OR every source onto its selected line.
    always_comb begin
        lines = '0;
        if (!legacy) begin
            lines[LEG_LINE0] = leg_q[0];
            lines[LEG_LINE1] = leg_q[1];
        end
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if ((status[ch] || pulse[ch]) && !msg_en[ch])
                lines[eff_line(legacy, ch, route[ch*ROUTE_W +: ROUTE_W])] = 1'b1;
        end
    end
endmodule

// File: rtl/irq_msg_sel.sv
// Registers one message-write request per cycle; lowest firing channel wins.
// Assumes fire_msg is already qualified by enables and message-enable bits.
module irq_msg_sel
    import irq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       fire_msg,
    input  logic [NUM_CH*MSG_W-1:0] words,
    output logic                    req,
    output logic [31:0]             addr,
    output logic [31:0]             data
);
    logic [MSG_W-1:0] pick;

    // Priority select of the lowest-index firing channel.
    always_comb begin
        pick = '0;
        for (int ch = NUM_CH - 1; ch >= 0; ch--)
            if (fire_msg[ch]) pick = words[ch*MSG_W +: MSG_W];
    end

    // Request register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req  <= 1'b0;
            addr <= '0;
            data <= '0;
        end else begin
            req <= |fire_msg;
            if (|fire_msg) begin
                addr <= pick[63:32];
                data <= pick[31:0];
            end
        end
    end
endmodule

// File: rtl/irq_router.sv
// Timer interrupt router: status register, line routing, legacy pass-through, message request.
// Assumes NUM_CH >= 2 and expiry inputs are single-cycle pulses.
module irq_router
    import irq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         tick_expire,
    input  logic [NUM_CH-1:0]         ch_enable,
    input  logic [NUM_CH-1:0]         ch_level,
    input  logic [NUM_CH-1:0]         ch_msg_en,
    input  logic [NUM_CH*ROUTE_W-1:0] ch_route,
    input  logic [NUM_CH*MSG_W-1:0]   ch_msg_word,
    input  logic                      glb_enable,
    input  logic                      legacy_mode,
    input  logic                      stat_clr_wr,
    input  logic [NUM_CH-1:0]         stat_clr_data,
    input  logic [1:0]                legacy_irq_in,
    output logic [LINES-1:0]          irq_out,
    output logic                      legacy_timer_en,
    output logic                      msg_req,
    output logic [31:0]               msg_addr,
    output logic [31:0]               msg_data,
    output logic [NUM_CH-1:0]         stat_bits
);
    logic [NUM_CH-1:0] active, fire, clr_mask, pulse;
    logic [1:0]        leg_q;

    assign active   = ch_enable & {NUM_CH{glb_enable}};
    assign fire     = tick_expire & active;
    assign clr_mask = stat_clr_data & {NUM_CH{stat_clr_wr}};

    // Sample the legacy inputs so line 8 can be restored on leaving legacy mode.
    always_ff @(posedge clk) begin
        if (!rst_n) leg_q <= '0;
        else        leg_q <= legacy_irq_in;
    end

    assign legacy_timer_en = ~legacy_mode;

    irq_status_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk(clk), .rst_n(rst_n), .fire(fire), .is_level(ch_level),
        .msg_en(ch_msg_en), .active(active), .clr_mask(clr_mask),
        .status(stat_bits), .pulse(pulse)
    );

    irq_line_map #(.NUM_CH(NUM_CH)) u_map (
        .legacy(legacy_mode), .route(ch_route), .status(stat_bits),
        .pulse(pulse), .msg_en(ch_msg_en), .leg_q(leg_q), .lines(irq_out)
    );

    irq_msg_sel #(.NUM_CH(NUM_CH)) u_msg (
        .clk(clk), .rst_n(rst_n), .fire_msg(fire & ch_msg_en),
        .words(ch_msg_word), .req(msg_req), .addr(msg_addr), .data(msg_data)
    );
endmodule

// File: rtl/irq_router_chk.sv
// Checker for the timer interrupt router, bound to the top module.
module irq_router_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] tick_expire,
    input logic [NUM_CH-1:0] ch_enable,
    input logic [NUM_CH-1:0] ch_level,
    input logic [NUM_CH-1:0] ch_msg_en,
    input logic              glb_enable,
    input logic              stat_clr_wr,
    input logic [NUM_CH-1:0] stat_clr_data,
    input logic              msg_req,
    input logic [NUM_CH-1:0] stat_bits
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        // R2: a status bit only rises after a level-mode expiry
        assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_bits[i]) |-> $past(tick_expire[i] && ch_level[i]));
        // R3: an edge-mode expiry leaves the status bit clear
        assert_edge_no_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_expire[i] && !ch_level[i] && !ch_msg_en[i]) |=> !stat_bits[i]);
        // R4: write-one-to-clear without a competing expiry clears the bit
        assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_clr_wr && stat_clr_data[i] && !tick_expire[i] && !$rose(ch_msg_en[i]))
            |=> !stat_bits[i]);
        // R5: a disabled channel holds no status
        assert_disabled_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(ch_enable[i] && glb_enable) |=> !stat_bits[i]);
    end
    // R8: a message request needs the global enable in the previous cycle
    assert_msg_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> $past(glb_enable && |(tick_expire & ch_enable & ch_msg_en)));
endmodule

bind irq_router irq_router_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_expire(tick_expire), .ch_enable(ch_enable),
    .ch_level(ch_level), .ch_msg_en(ch_msg_en), .glb_enable(glb_enable),
    .stat_clr_wr(stat_clr_wr), .stat_clr_data(stat_clr_data),
    .msg_req(msg_req), .stat_bits(stat_bits)
);

// File: tb/sim_irq_router.sv
module sim_irq_router;
    localparam int N = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] expire = '0, en = '0, lvl = '0, msgen = '0, swdata = '0;
    logic [N*5-1:0] route = '0;
    logic [N*64-1:0] words = '0;
    logic genable = 1'b0, legacy = 1'b0, swr = 1'b0;
    logic [1:0] legin = '0;
    logic [31:0] irq_out, msg_addr, msg_data;
    logic legacy_timer_en, msg_req;
    logic [N-1:0] stat_bits;

    // model state
    logic [N-1:0] m_status = '0, m_pulse = '0, m_msgq = '0;
    logic [1:0] m_legq = '0;
    logic m_req = 1'b0;
    logic [31:0] m_addr = '0, m_data = '0;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    irq_router #(.NUM_CH(N)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_expire(expire), .ch_enable(en), .ch_level(lvl),
        .ch_msg_en(msgen), .ch_route(route), .ch_msg_word(words), .glb_enable(genable),
        .legacy_mode(legacy), .stat_clr_wr(swr), .stat_clr_data(swdata),
        .legacy_irq_in(legin), .irq_out(irq_out), .legacy_timer_en(legacy_timer_en),
        .msg_req(msg_req), .msg_addr(msg_addr), .msg_data(msg_data), .stat_bits(stat_bits)
    );

    function automatic logic [31:0] exp_lines();
        logic [31:0] l = '0;
        if (!legacy) begin l[0] = m_legq[0]; l[8] = m_legq[1]; end
        for (int i = 0; i < N; i++) begin
            if ((m_status[i] || m_pulse[i]) && !msgen[i]) begin
                if (legacy && i == 0) l[0] = 1'b1;
                else if (legacy && i == 1) l[8] = 1'b1;
                else l[route[i*5 +: 5]] = 1'b1;
            end
        end
        return l;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one clock with current stimulus, update model, compare all outputs.
    task automatic step(string tag);
        logic [N-1:0] act, fire, ns, np;
        logic nreq = 1'b0;
        logic [31:0] na = m_addr, nd = m_data;
        act  = en & {N{genable}};
        fire = expire & act;
        for (int i = 0; i < N; i++) begin
            if (!act[i]) ns[i] = 1'b0;
            else if (msgen[i] && !m_msgq[i]) ns[i] = 1'b0;
            else if (fire[i] && !msgen[i]) ns[i] = lvl[i];
            else if (swr && swdata[i]) ns[i] = 1'b0;
            else ns[i] = m_status[i];
        end
        np = fire & ~lvl & ~msgen;
        for (int i = N - 1; i >= 0; i--)
            if (fire[i] && msgen[i]) begin
                nreq = 1'b1; na = words[i*64+32 +: 32]; nd = words[i*64 +: 32];
            end
        @(posedge clk); #1;
        if (!rst_n) begin
            ns = '0; np = '0; nreq = 1'b0; na = '0; nd = '0;
        end
        m_status = ns; m_pulse = np; m_req = nreq; m_addr = na; m_data = nd;
        m_msgq = rst_n ? msgen : '0;
        m_legq = rst_n ? legin : 2'b00;
        chk({tag, " status R2 R4 R5 R9"}, 64'(stat_bits), 64'(m_status));
        chk({tag, " lines R1 R3 R6 R7"}, 64'(irq_out), 64'(exp_lines()));
        chk({tag, " timer_en R7"}, 64'(legacy_timer_en), 64'(!legacy));
        chk({tag, " req R8"}, 64'(msg_req), 64'(m_req));
        if (m_req) chk({tag, " msg R8"}, {msg_addr, msg_data}, {m_addr, m_data});
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd11));
        step("reset");
        step("reset");
        chk("reset R2", 64'(stat_bits), 0);
        chk("reset R1", 64'(irq_out), 0);
        rst_n = 1'b1; genable = 1'b1; en = '1; lvl = 4'b0111;
        route = {5'd5, 5'd17, 5'd3, 5'd20};
        // R1/R2: level channel 2 onto line 17
        expire = 4'b0100; step("R2 dir");
        expire = '0; step("R2 hold");
        chk("R1 line17", 64'(irq_out), 64'(32'h1 << 17));
        // R4: zero mask keeps bit, one mask clears
        swr = 1'b1; swdata = 4'b1011; step("R4 keep");
        chk("R4 keep", 64'(stat_bits), 64'(4'b0100));
        swdata = 4'b0100; expire = 4'b0100; step("R4 expiry wins");
        chk("R4 expiry wins", 64'(stat_bits), 64'(4'b0100));
        expire = '0; step("R4 clear");
        chk("R4 clear", 64'(irq_out), 0);
        swr = 1'b0; swdata = '0;
        // R3: edge channel 3 on line 5
        expire = 4'b1000; step("R3 pulse");
        chk("R3 pulse", 64'(irq_out), 64'(32'h20));
        expire = '0; step("R3 end");
        chk("R3 end", 64'(irq_out), 0);
        // R6: legacy routing of channels 0 and 1
        legacy = 1'b1; legin = 2'b10; expire = 4'b0011; step("R6 dir");
        expire = '0; step("R6 hold");
        chk("R6 lines", 64'(irq_out), 64'(32'h101));
        // R5: global disable clears all
        genable = 1'b0; expire = 4'b0011; step("R5 dir");
        chk("R5 clear", 64'(stat_bits), 0);
        chk("R7 blocked", 64'(irq_out), 0);
        expire = '0; genable = 1'b1;
        // R7: leaving legacy restores line 8
        legacy = 1'b0; step("R7 restore");
        chk("R7 line8", 64'(irq_out), 64'(32'h100));
        legin = '0;
        // R9: message enable rise clears status
        expire = 4'b0100; step("R9 set");
        expire = '0; msgen = 4'b0100; step("R9 rise");
        chk("R9 cleared", 64'(stat_bits), 0);
        // R8: two message channels, lowest wins
        msgen = 4'b1010; words = {64'hA0A0_0003_D0D0_0003, 64'h0, 64'hA0A0_0001_D0D0_0001, 64'h0};
        expire = 4'b1010; step("R8 dir");
        chk("R8 pick", {msg_addr, msg_data}, 64'hA0A0_0001_D0D0_0001);
        expire = '0; step("R8 end");
        // random mix
        for (int k = 0; k < 3000; k++) begin
            expire = 4'($urandom) & 4'($urandom);
            if ($urandom_range(0, 15) == 0) en = 4'($urandom);
            if ($urandom_range(0, 15) == 0) lvl = 4'($urandom);
            if ($urandom_range(0, 20) == 0) msgen = 4'($urandom);
            if ($urandom_range(0, 30) == 0) route = {5'($urandom_range(0, 3)), 5'($urandom), 5'($urandom_range(0, 3)), 5'($urandom)};
            if ($urandom_range(0, 30) == 0) words = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            genable = ($urandom_range(0, 40) != 0);
            if ($urandom_range(0, 40) == 0) legacy = ~legacy;
            legin = 2'($urandom);
            swr = ($urandom_range(0, 3) == 0);
            swdata = 4'($urandom);
            step("random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule